// File: doc/BRIEF.md
# Double-Buffered Audio Frame Fetch Sequencer

This block walks a frame of 16-bit sample words in memory, from a programmed start address up to an end address that points one byte past the last sample. Each word is fetched through a single-word request/acknowledge read port. The word is pushed into a downstream sample FIFO in the same cycle the memory accepts the request. Software programs the block through byte-wide registers. A two-bit run-control field selects one of three modes: off, play the frame once, or replay it without end. The start and end addresses are written into holding registers. The holding values are copied into the live frame only when the engine starts from idle or when it crosses a frame boundary. This lets software queue the next frame while the current one is still being fetched.

A `sound_active` line is high while words of the frame remain to be fetched. In repeat mode it drops for exactly one cycle at each wrap, so an external event counter can count repetitions. `irq_line` is `sound_active` exclusive-ORed with an external monitor-sense input.

The sequencer has two states. ST_IDLE: nothing is fetched and `sound_active` is low. ST_RUN: the frame is being fetched. Its transitions are as follows:
- START (ST_IDLE to ST_RUN): control enabled. The frame is loaded from the holding registers.
- WRAP (ST_RUN to ST_RUN): repeat mode at the boundary. The frame is reloaded.
- FINISH (ST_RUN to ST_IDLE): play-once mode at the boundary. The control field is cleared.
- HALT (ST_RUN to ST_IDLE): control disabled.

Top module: `frame_dma`

## Requirements
- R1: After reset the control field reads 00, every holding register and the address counter read 0, and both `mem_req` and `sound_active` are low.
- R2: Control field encoding (register index 0, bits [1:0]): 01 = play once, 11 = repeat. Values 00 and 10 are off: no request is issued and `sound_active` stays low.
- R3: The register indices are as follows. Index 0 is control. Indices 1, 2 and 3 are the holding start address bytes [23:16], [15:8] and [7:0]. Indices 4, 5 and 6 are the holding end address bytes in the same byte order. Indices 7, 8 and 9 read the address counter in the same byte order. Writes to indices 7 to 9 have no effect, and unused indices read 0.
- R4: Writes to the start and end holding registers leave the frame in progress unchanged. The frame in progress switches to the holding values at START and at WRAP.
- R5: While in ST_RUN with data left, `mem_req` is asserted with `mem_addr` equal to the counter. On `mem_ack`, `mem_rdata` appears on `fifo_data` with `fifo_push` in that same cycle, and the counter advances by 2.
- R6: While `fifo_full` is high, `mem_req` and `fifo_push` stay low.
- R7: The end address is exclusive: the last word fetched is at end − 2. `sound_active` goes low in the cycle right after the last word is accepted.
- R8: In play-once mode, reaching the end address returns the control field to 00 and the engine to ST_IDLE.
- R9: In repeat mode, reaching the end address keeps the engine in ST_RUN. `sound_active` is low for exactly one cycle, and requests resume from the reloaded start address in the next cycle.
- R10: Writing an off value to control while a frame runs drops `mem_req` and `sound_active` in the next cycle.
- R11: `irq_line` always equals `sound_active` XOR `monitor_sense`.
- R12: A software write to the control field in the cycle FINISH would clear it takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register index for writes |
| wr_data | input | 8 | Register write data |
| rd_sel | input | 4 | Register index for reads |
| rd_data | output | 8 | Register read data (combinational) |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 24 | Byte address of the requested word |
| mem_ack | input | 1 | Memory accepts the request; data valid |
| mem_rdata | input | 16 | Read word |
| fifo_push | output | 1 | Push fetched word into the sample FIFO |
| fifo_data | output | 16 | Word pushed into the FIFO |
| fifo_full | input | 1 | Downstream FIFO cannot accept a word |
| monitor_sense | input | 1 | External level combined into the interrupt line |
| sound_active | output | 1 | Frame words remain to be fetched |
| irq_line | output | 1 | `sound_active` XOR `monitor_sense` |

## Verification
The hardest case to reach is the FINISH boundary in the exact cycle that software rewrites the control field. Only that cycle exercises the clear-versus-write priority. The bench reaches it by consulting its behavioural model before every cycle. It issues the control write precisely when the model reports the counter sitting on the end address in play-once mode. Frame queuing during repeat playback is driven by writing new holding values while a short frame wraps under random acknowledge and FIFO-full patterns.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } fdma_state_t;

    localparam logic [1:0] CTRL_OFF  = 2'b00;
    localparam logic [1:0] CTRL_ONCE = 2'b01;
    localparam logic [1:0] CTRL_LOOP = 2'b11;
endpackage

// File: rtl/fdma_regs.sv
module fdma_regs #(
    parameter int ADDR_W = 24,
    parameter int REG_W  = 8,
    parameter int NPART  = 3,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              ctrl_clr,
    output logic [1:0]        ctrl,
    output logic [ADDR_W-1:0] hold_start,
    output logic [ADDR_W-1:0] hold_end
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= fdma_pkg::CTRL_OFF;
        end else if (wr_en && wr_sel == '0) begin
            ctrl <= wr_data[1:0];
        end else if (ctrl_clr) begin
            ctrl <= fdma_pkg::CTRL_OFF;
        end
    end

    // byte lane p = 0 is the most significant byte
    for (genvar p = 0; p < NPART; p++) begin : g_lane
        localparam int MSB = ADDR_W - 1 - p * REG_W;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_start[MSB -: REG_W] <= '0;
                hold_end[MSB -: REG_W]   <= '0;
            end else if (wr_en) begin
                if (wr_sel == SEL_W'(1 + p))
                    hold_start[MSB -: REG_W] <= wr_data;
                if (wr_sel == SEL_W'(1 + NPART + p))
                    hold_end[MSB -: REG_W] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/fdma_seq.sv
module fdma_seq #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            ctrl,
    input  logic [ADDR_W-1:0]     hold_start,
    input  logic [ADDR_W-1:0]     hold_end,
    input  logic                  fifo_full,
    input  logic                  mem_ack,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  mem_req,
    output logic                  fifo_push,
    output logic [DATA_W-1:0]     fifo_data,
    output logic                  sound_active,
    output logic                  ctrl_clr,
    output logic [ADDR_W-1:0]     cur_addr,
    output logic [ADDR_W-1:0]     live_end,
    output fdma_pkg::fdma_state_t state
);
    import fdma_pkg::*;

    localparam int STEP = DATA_W / 8;

    fdma_state_t nxt;
    logic        enabled, looping, at_end, load;

    assign enabled = ctrl[0];
    assign looping = (ctrl == CTRL_LOOP);
    assign at_end  = (cur_addr == live_end);

    // next state and transition side effects
    always_comb begin
        nxt      = state;
        load     = 1'b0;
        ctrl_clr = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (enabled) begin            // START
                    nxt  = ST_RUN;
                    load = 1'b1;
                end
            end
            ST_RUN: begin
                if (!enabled) begin           // HALT
                    nxt = ST_IDLE;
                end else if (at_end) begin
                    if (looping) begin        // WRAP
                        load = 1'b1;
                    end else begin            // FINISH
                        nxt      = ST_IDLE;
                        ctrl_clr = 1'b1;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        sound_active = (state == ST_RUN) && enabled && !at_end;
        mem_req      = sound_active && !fifo_full;
        fifo_push    = mem_req && mem_ack;
        fifo_data    = mem_rdata;
    end

    // live frame and address counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            live_end <= '0;
        end else if (load) begin
            cur_addr <= hold_start;
            live_end <= hold_end;
        end else if (fifo_push) begin
            cur_addr <= cur_addr + ADDR_W'(STEP);
        end
    end
endmodule

// File: rtl/fdma_rdmux.sv
module fdma_rdmux #(
    parameter int ADDR_W = 24,
    parameter int REG_W  = 8,
    parameter int NPART  = 3,
    parameter int SEL_W  = 4
) (
    input  logic [SEL_W-1:0]  rd_sel,
    input  logic [1:0]        ctrl,
    input  logic [ADDR_W-1:0] hold_start,
    input  logic [ADDR_W-1:0] hold_end,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic [REG_W-1:0]  rd_data
);
    always_comb begin
        rd_data = '0;
        if (rd_sel == '0) rd_data = REG_W'(ctrl);
        for (int p = 0; p < NPART; p++) begin
            if (rd_sel == SEL_W'(1 + p))
                rd_data = hold_start[ADDR_W - 1 - p * REG_W -: REG_W];
            if (rd_sel == SEL_W'(1 + NPART + p))
                rd_data = hold_end[ADDR_W - 1 - p * REG_W -: REG_W];
            if (rd_sel == SEL_W'(1 + 2 * NPART + p))
                rd_data = cur_addr[ADDR_W - 1 - p * REG_W -: REG_W];
        end
    end
endmodule

// File: rtl/frame_dma.sv
module frame_dma #(
    parameter int  ADDR_W = 24,
    parameter int  DATA_W = 16,
    parameter int  REG_W  = 8,
    localparam int NPART  = ADDR_W / REG_W,
    localparam int NREG   = 3 * NPART + 1,
    localparam int SEL_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [REG_W-1:0]  rd_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fifo_push,
    output logic [DATA_W-1:0] fifo_data,
    input  logic              fifo_full,
    input  logic              monitor_sense,
    output logic              sound_active,
    output logic              irq_line
);
    logic [1:0]            ctrl_q;
    logic                  ctrl_clr;
    logic [ADDR_W-1:0]     hold_start, hold_end, cur_addr, live_end;
    fdma_pkg::fdma_state_t seq_state;

    fdma_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W), .NPART(NPART), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctrl_clr(ctrl_clr), .ctrl(ctrl_q), .hold_start(hold_start), .hold_end(hold_end)
    );

    fdma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .hold_start(hold_start),
        .hold_end(hold_end), .fifo_full(fifo_full), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_req(mem_req), .fifo_push(fifo_push),
        .fifo_data(fifo_data), .sound_active(sound_active), .ctrl_clr(ctrl_clr),
        .cur_addr(cur_addr), .live_end(live_end), .state(seq_state)
    );

    fdma_rdmux #(.ADDR_W(ADDR_W), .REG_W(REG_W), .NPART(NPART), .SEL_W(SEL_W)) u_rdmux (
        .rd_sel(rd_sel), .ctrl(ctrl_q), .hold_start(hold_start), .hold_end(hold_end),
        .cur_addr(cur_addr), .rd_data(rd_data)
    );

    assign mem_addr = cur_addr;
    assign irq_line = sound_active ^ monitor_sense;
endmodule

// File: rtl/fdma_chk.sv
module fdma_chk #(
    parameter int ADDR_W = 24,
    parameter int REG_W  = 8,
    parameter int SEL_W  = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [SEL_W-1:0]      wr_sel,
    input logic [REG_W-1:0]      wr_data,
    input logic [1:0]            ctrl_q,
    input fdma_pkg::fdma_state_t seq_state,
    input logic [ADDR_W-1:0]     cur_addr,
    input logic [ADDR_W-1:0]     live_end,
    input logic                  mem_req,
    input logic                  mem_ack,
    input logic                  fifo_full,
    input logic                  fifo_push,
    input logic                  sound_active
);
    import fdma_pkg::*;

    logic ctrl_wr;
    assign ctrl_wr = wr_en && (wr_sel == '0);

    a_r6_no_req_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !mem_req && !fifo_push);

    a_r5_push_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> mem_req && mem_ack);

    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |=> cur_addr == $past(cur_addr) + ADDR_W'(2));

    a_r7_active_before_end: assert property (@(posedge clk) disable iff (!rst_n)
        sound_active |-> cur_addr != live_end);

    a_r2_off_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[0] |-> !mem_req && !sound_active);

    a_r8_once_finishes: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_RUN && ctrl_q == CTRL_ONCE && cur_addr == live_end && !ctrl_wr)
        |=> (ctrl_q == CTRL_OFF && seq_state == ST_IDLE));

    a_r9_loop_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_RUN && ctrl_q == CTRL_LOOP && cur_addr == live_end && !ctrl_wr)
        |=> seq_state == ST_RUN);

    a_r10_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !wr_data[0]) |=> !mem_req && !sound_active);
endmodule

bind frame_dma fdma_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .seq_state(seq_state), .cur_addr(cur_addr), .live_end(live_end),
    .mem_req(mem_req), .mem_ack(mem_ack), .fifo_full(fifo_full),
    .fifo_push(fifo_push), .sound_active(sound_active)
);

// File: tb/frame_dma_tb.sv
module frame_dma_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  rd_sel = '0;
    logic [7:0]  rd_data;
    logic        mem_req, fifo_push, sound_active, irq_line;
    logic [23:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata, fifo_data;
    logic        fifo_full = 1'b0;
    logic        monitor_sense = 1'b0;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit auto_io = 0, auto_rd = 1;
    logic [15:0] lfsr = 16'hACE1;

    // behavioural reference state
    bit          m_run;
    logic [1:0]  m_ctrl;
    logic [23:0] m_hs, m_he, m_cur, m_lend;

    // pulse / observation tracking
    bit track = 0;
    int lowlen = 0, pulses = 0, badw = 0;
    bit seen_b = 0;

    always #5 clk = ~clk;

    frame_dma u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .fifo_push(fifo_push),
        .fifo_data(fifo_data), .fifo_full(fifo_full), .monitor_sense(monitor_sense),
        .sound_active(sound_active), .irq_line(irq_line)
    );

    function automatic logic [15:0] word_of(input logic [23:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] + 8'h11};
    endfunction

    assign mem_rdata = word_of(mem_addr);

    task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [3:0] s);
        case (s)
            4'd0: return {6'b0, m_ctrl};
            4'd1: return m_hs[23:16];
            4'd2: return m_hs[15:8];
            4'd3: return m_hs[7:0];
            4'd4: return m_he[23:16];
            4'd5: return m_he[15:8];
            4'd6: return m_he[7:0];
            4'd7: return m_cur[23:16];
            4'd8: return m_cur[15:8];
            4'd9: return m_cur[7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        m_run = 0; m_ctrl = 2'b00; m_hs = '0; m_he = '0; m_cur = '0; m_lend = '0;
    endtask

    // one clock: inputs set at negedge, compare, advance model, cross posedge
    task automatic tick();
        logic en, lp, ate, e_act, e_req, e_push, clr, ld;
        if (auto_io) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_ack   = lfsr[0] | lfsr[3];
            fifo_full = (lfsr[6:5] == 2'b11);
        end
        if (auto_rd) rd_sel = 4'(cyc % 11);
        if (cyc % 7 == 0) monitor_sense = ~monitor_sense;
        #1;
        if (!rst_n) model_reset();
        en = m_ctrl[0]; lp = (m_ctrl == 2'b11); ate = (m_cur == m_lend);
        e_act  = m_run && en && !ate;
        e_req  = e_act && !fifo_full;
        e_push = e_req && mem_ack;
        cmp(32'(mem_req), 32'(e_req), "R6 mem_req");
        if (e_req) cmp(32'(mem_addr), 32'(m_cur), "R5 mem_addr");
        cmp(32'(fifo_push), 32'(e_push), "R5 fifo_push");
        if (e_push) cmp(32'(fifo_data), 32'(word_of(m_cur)), "R5 fifo_data");
        cmp(32'(sound_active), 32'(e_act), "R7 sound_active");
        cmp(32'(irq_line), 32'(e_act ^ monitor_sense), "R11 irq_line");
        cmp(32'(rd_data), 32'(exp_rd(rd_sel)), "R3 rd_data");
        if (e_req && mem_addr == 24'h000200) seen_b = 1;
        if (track) begin
            if (!sound_active) lowlen++;
            else if (lowlen > 0) begin
                pulses++;
                if (lowlen != 1) badw++;
                lowlen = 0;
            end
        end
        // model next state (pre-edge values)
        if (rst_n) begin
            clr = 0; ld = 0;
            if (!m_run) begin
                if (en) begin m_run = 1; ld = 1; end
            end else if (!en) m_run = 0;
            else if (ate) begin
                if (lp) ld = 1;
                else begin m_run = 0; clr = 1; end
            end
            if (ld) begin m_cur = m_hs; m_lend = m_he; end
            else if (e_push) m_cur = m_cur + 24'd2;
            if (clr) m_ctrl = 2'b00;
            if (wr_en) begin
                case (wr_sel)
                    4'd0: m_ctrl = wr_data[1:0];
                    4'd1: m_hs[23:16] = wr_data;
                    4'd2: m_hs[15:8]  = wr_data;
                    4'd3: m_hs[7:0]   = wr_data;
                    4'd4: m_he[23:16] = wr_data;
                    4'd5: m_he[15:8]  = wr_data;
                    4'd6: m_he[7:0]   = wr_data;
                    default: ;
                endcase
            end
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic wr(input logic [3:0] s, input logic [7:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic set_frame(input logic [23:0] s, input logic [23:0] e);
        wr(4'd1, s[23:16]); wr(4'd2, s[15:8]); wr(4'd3, s[7:0]);
        wr(4'd4, e[23:16]); wr(4'd5, e[15:8]); wr(4'd6, e[7:0]);
    endtask

    task automatic read_chk(input logic [3:0] s, input logic [7:0] e, input string tag);
        auto_rd = 0; rd_sel = s;
        #1 cmp(32'(rd_data), 32'(e), tag);
        tick();
        auto_rd = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        model_reset();
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        cmp(32'(sound_active), 0, "R1 active after reset");
        cmp(32'(mem_req), 0, "R1 req after reset");
        read_chk(4'd0, 8'h00, "R1 ctrl after reset");
        read_chk(4'd9, 8'h00, "R1 counter after reset");

        // R8 / R7 play once: 512-byte frame, random ack and full
        auto_io = 1;
        set_frame(24'h018AA0, 24'h018CA0);
        wr(4'd0, 8'h01);
        for (int i = 0; i < 3000 && !(m_run == 0 && m_ctrl == 2'b00); i++) tick();
        cmp(32'(m_cur), 32'h018CA0, "R7 model reached exclusive end");
        read_chk(4'd0, 8'h00, "R8 ctrl cleared after once");
        read_chk(4'd9, 8'hA0, "R7 counter low byte at end");
        cmp(32'(sound_active), 0, "R8 idle after once");

        // R2 value 10 is off
        wr(4'd0, 8'h02);
        repeat (5) tick();
        cmp(32'({sound_active, mem_req}), 0, "R2 ctrl 10 is off");
        wr(4'd0, 8'h00);

        // R9 / R4 repeat with queued next frame
        set_frame(24'h000100, 24'h000108);
        wr(4'd0, 8'h03);
        track = 1; lowlen = 0; pulses = 0; badw = 0;
        set_frame(24'h000200, 24'h000206);
        repeat (200) tick();
        track = 0;
        cmp(32'(pulses >= 2), 1, "R9 wrap pulses seen");
        cmp(32'(badw), 0, "R9 wrap pulse width one cycle");
        cmp(32'(seen_b), 1, "R4 queued frame taken at wrap");

        // R6 held full
        auto_io = 0; fifo_full = 1; mem_ack = 1;
        repeat (5) begin
            tick();
            cmp(32'(mem_req), 0, "R6 no request while full");
        end
        fifo_full = 0;
        repeat (4) tick();

        // R10 stop mid-frame
        wr(4'd0, 8'h00);
        #1 cmp(32'({sound_active, mem_req}), 0, "R10 stop drops at once");
        tick();

        // R3 counter read-only
        wr(4'd7, 8'hFF); wr(4'd8, 8'hFF); wr(4'd9, 8'hFF);
        read_chk(4'd9, m_cur[7:0], "R3 counter ignores writes");
        read_chk(4'd12, 8'h00, "R3 unused index reads 0");

        // R12 control write at the FINISH cycle
        set_frame(24'h000300, 24'h000304);
        wr(4'd0, 8'h01);
        for (int i = 0; i < 50; i++) begin
            if (m_run && m_cur == m_lend && m_ctrl == 2'b01) begin
                wr(4'd0, 8'h03);
                break;
            end
            tick();
        end
        read_chk(4'd0, 8'h03, "R12 write wins over clear");
        repeat (10) tick();
        wr(4'd0, 8'h00);
        repeat (3) tick();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule